// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is a boundary-scan data register assembled from typed cells and placed between the core logic and the pads. It handles four kinds of cell. Observe cells sit on input-only pins. Single cells sit on two-state outputs. Internal cells sample a core net and have no pad. Bidirectional or tristate pins each take two cells: a data cell and a control cell. A control cell holding 1 turns that pin's driver off.

An external test-access controller drives the block with four signals on the scan clock: capture, shift, update and mode. On a rising edge, capture loads every cell from its source and shift moves the chain one place towards the serial output. On a falling edge, update copies the pad-driving cells into hold latches. While mode is low the core reaches the pads directly. While mode is high the hold latches set the pad data and the pad enables. Cell 0 drives the serial output, and the highest-numbered cell receives the serial input.

Top module: `bscan_pin_chain`

## Requirements
- R1: While trst_n is low, every control cell resets to 1 and every other cell resets to 0, in both the shift stage and the hold latches. After reset, with mode high, every bidirectional pad enable is 0 and every pad data output is 0.
- R2: With mode low, pad_obuf equals core_obuf, pad_bidir_out equals core_bidir_data and pad_bidir_oe equals core_bidir_oe. At every mode setting, core_in follows pad_in and core_bidir_in follows pad_bidir_in.
- R3: On a rising scan-clock edge with shift_en high and capture_en low, each cell takes the value of the cell one number above it, and the top cell L-1 takes tdi. tdo always shows cell 0.
- R4: On a rising edge with capture_en high, the cells load as follows:
  - a bidirectional data cell loads pad_bidir_in, whatever the state of the driver;
  - a control cell loads the inverse of core_bidir_oe;
  - an output cell loads core_obuf;
  - an input cell loads pad_in;
  - an internal cell loads core_int.
- R5: The cells are laid out as follows, where NB, NO and NI are the bidirectional, output and input pin counts:
  - bidirectional pin k has its data cell at 2k and its control cell at 2k+1, one place nearer tdi;
  - output pin j is at cell 2·NB+j;
  - input pin j is at cell 2·NB+NO+j;
  - internal cells follow from 2·NB+NO+NI upwards.
- R6: On a falling scan-clock edge with update_en high, the hold latches copy the matching shift cells. When update_en is low they hold, so shifting and capturing leave the pads unchanged while mode is high.
- R7: With mode high, pad_bidir_out[k] is the data latch of pin k. pad_bidir_oe[k] is the inverse of its control latch, so a control value of 1 puts the pin in high impedance. pad_obuf[j] is the latch of output cell j.
- R8: When capture_en and shift_en are both high on the same edge, the capture takes place and no shift occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial scan input |
| capture_en | input | 1 | Capture all cells on the rising edge |
| shift_en | input | 1 | Shift the chain towards cell 0 on the rising edge |
| update_en | input | 1 | Load the hold latches on the falling edge |
| mode | input | 1 | 0: core drives the pads; 1: hold latches drive the pads |
| tdo | output | 1 | Serial scan output (cell 0) |
| core_obuf | input | NUM_OUT | Core data for the two-state outputs |
| core_bidir_data | input | NUM_BIDIR | Core data for the bidirectional pins |
| core_bidir_oe | input | NUM_BIDIR | Core output enables, active high |
| core_int | input | NUM_INT | Core nets observed by the internal cells |
| pad_in | input | NUM_IN | Pad values of the input-only pins |
| pad_bidir_in | input | NUM_BIDIR | Received values of the bidirectional pins |
| pad_obuf | output | NUM_OUT | Two-state pad data |
| pad_bidir_out | output | NUM_BIDIR | Bidirectional pad data |
| pad_bidir_oe | output | NUM_BIDIR | Bidirectional pad enables, active high |
| core_in | output | NUM_IN | Input pins returned to the core |
| core_bidir_in | output | NUM_BIDIR | Bidirectional pins returned to the core |

## Verification
The capture path is run with thirty-two hashed patterns of core data, core enables, pad values and internal nets. A swapped cell position, a missing inversion on a control cell, or a data cell that depends on its enable each produce a different readout. Thirty-two vectors are shifted in under mode high. Each is checked first while only shifted and then after an update, which separates shift-stage leakage from a latch that fails to load, and covers every enable combination of the bidirectional pins. Two back-to-back scans confirm the serial ordering, and a combined capture-and-shift edge shows whether capture wins.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [2:0] {
        CELL_BDATA,
        CELL_BCTRL,
        CELL_OUT,
        CELL_IN,
        CELL_INT
    } cell_kind_e;

    // Kind of the cell at chain position idx (0 = tdo end).
    function automatic cell_kind_e kind_at(int idx, int nb, int no, int ni);
        if (idx < 2 * nb)
            return (idx % 2 == 0) ? CELL_BDATA : CELL_BCTRL;
        else if (idx < 2 * nb + no)
            return CELL_OUT;
        else if (idx < 2 * nb + no + ni)
            return CELL_IN;
        else
            return CELL_INT;
    endfunction

    // Pin index inside the cell's own group.
    function automatic int slot_at(int idx, int nb, int no, int ni);
        if (idx < 2 * nb)
            return idx / 2;
        else if (idx < 2 * nb + no)
            return idx - 2 * nb;
        else if (idx < 2 * nb + no + ni)
            return idx - 2 * nb - no;
        else
            return idx - 2 * nb - no - ni;
    endfunction

endpackage

// File: rtl/bscan_capture_route.sv
module bscan_capture_route #(
    parameter int NUM_BIDIR = 4,
    parameter int NUM_OUT   = 3,
    parameter int NUM_IN    = 3,
    parameter int NUM_INT   = 2,
    localparam int CHAIN_LEN = 2 * NUM_BIDIR + NUM_OUT + NUM_IN + NUM_INT
) (
    input  logic [NUM_OUT-1:0]   core_obuf,
    input  logic [NUM_BIDIR-1:0] core_bidir_oe,
    input  logic [NUM_BIDIR-1:0] pad_bidir_in,
    input  logic [NUM_IN-1:0]    pad_in,
    input  logic [NUM_INT-1:0]   core_int,
    output logic [CHAIN_LEN-1:0] cap_vec
);
    import bscan_pkg::*;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
        localparam cell_kind_e KIND = kind_at(i, NUM_BIDIR, NUM_OUT, NUM_IN);
        localparam int         SLOT = slot_at(i, NUM_BIDIR, NUM_OUT, NUM_IN);
        if (KIND == CELL_BDATA) begin : g_bdata
            // R4: received value, independent of the driver state
            assign cap_vec[i] = pad_bidir_in[SLOT];
        end else if (KIND == CELL_BCTRL) begin : g_bctrl
            // R4: control polarity is 1 = disabled
            assign cap_vec[i] = ~core_bidir_oe[SLOT];
        end else if (KIND == CELL_OUT) begin : g_out
            assign cap_vec[i] = core_obuf[SLOT];
        end else if (KIND == CELL_IN) begin : g_in
            assign cap_vec[i] = pad_in[SLOT];
        end else begin : g_int
            assign cap_vec[i] = core_int[SLOT];
        end
    end

endmodule

// File: rtl/bscan_shift_path.sv
module bscan_shift_path #(
    parameter int                 CHAIN_LEN = 16,
    parameter logic [CHAIN_LEN-1:0] RST_VEC = '0
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic [CHAIN_LEN-1:0] cap_vec,
    output logic [CHAIN_LEN-1:0] cells,
    output logic                 tdo
);
    typedef struct packed {
        logic [CHAIN_LEN-1:0] cells;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (capture_en) begin
            state_d.cells = cap_vec;                       // R8: capture wins
        end else if (shift_en) begin
            state_d.cells = {tdi, state_q.cells[CHAIN_LEN-1:1]};
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= '{cells: RST_VEC};
        else         state_q <= state_d;
    end

    assign cells = state_q.cells;
    assign tdo   = state_q.cells[0];

    assert_capture_load_R4: assert property (@(posedge tck) disable iff (!trst_n)
        capture_en |=> cells == $past(cap_vec));
    assert_shift_move_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=> cells[CHAIN_LEN-2:0] == $past(cells[CHAIN_LEN-1:1]));
    assert_tdi_entry_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=> cells[CHAIN_LEN-1] == $past(tdi));
    assert_idle_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (!shift_en && !capture_en) |=> $stable(cells));

endmodule

// File: rtl/bscan_update_bank.sv
module bscan_update_bank #(
    parameter int                  UPD_LEN = 11,
    parameter logic [UPD_LEN-1:0]  RST_VEC = '0
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               update_en,
    input  logic [UPD_LEN-1:0] shift_cells,
    output logic [UPD_LEN-1:0] latch
);
    typedef struct packed {
        logic [UPD_LEN-1:0] latch;
    } upd_state_t;

    upd_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (update_en) state_d.latch = shift_cells;
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= '{latch: RST_VEC};
        else         state_q <= state_d;
    end

    assign latch = state_q.latch;

    assert_latch_hold_R6: assert property (@(negedge tck) disable iff (!trst_n)
        !update_en |=> $stable(latch));
    assert_latch_load_R6: assert property (@(negedge tck) disable iff (!trst_n)
        update_en |=> latch == $past(shift_cells));

endmodule

// File: rtl/bscan_pad_mux.sv
module bscan_pad_mux #(
    parameter int NUM_BIDIR = 4,
    parameter int NUM_OUT   = 3,
    parameter int NUM_IN    = 3,
    localparam int UPD_LEN  = 2 * NUM_BIDIR + NUM_OUT
) (
    input  logic                 mode,
    input  logic [UPD_LEN-1:0]   latch,
    input  logic [NUM_OUT-1:0]   core_obuf,
    input  logic [NUM_BIDIR-1:0] core_bidir_data,
    input  logic [NUM_BIDIR-1:0] core_bidir_oe,
    input  logic [NUM_BIDIR-1:0] pad_bidir_in,
    input  logic [NUM_IN-1:0]    pad_in,
    output logic [NUM_OUT-1:0]   pad_obuf,
    output logic [NUM_BIDIR-1:0] pad_bidir_out,
    output logic [NUM_BIDIR-1:0] pad_bidir_oe,
    output logic [NUM_IN-1:0]    core_in,
    output logic [NUM_BIDIR-1:0] core_bidir_in
);
    for (genvar k = 0; k < NUM_BIDIR; k++) begin : g_bidir
        // R7: data latch at 2k, control latch at 2k+1 (1 = high impedance)
        assign pad_bidir_out[k] = mode ? latch[2*k]       : core_bidir_data[k];
        assign pad_bidir_oe[k]  = mode ? ~latch[2*k + 1]  : core_bidir_oe[k];
    end

    for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
        assign pad_obuf[j] = mode ? latch[2*NUM_BIDIR + j] : core_obuf[j];
    end

    assign core_in       = pad_in;
    assign core_bidir_in = pad_bidir_in;

endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain #(
    parameter int NUM_BIDIR = 4,
    parameter int NUM_OUT   = 3,
    parameter int NUM_IN    = 3,
    parameter int NUM_INT   = 2
) (
    input  logic                 tck,
    input  logic                 trst_n,
    input  logic                 tdi,
    input  logic                 capture_en,
    input  logic                 shift_en,
    input  logic                 update_en,
    input  logic                 mode,
    output logic                 tdo,
    input  logic [NUM_OUT-1:0]   core_obuf,
    input  logic [NUM_BIDIR-1:0] core_bidir_data,
    input  logic [NUM_BIDIR-1:0] core_bidir_oe,
    input  logic [NUM_INT-1:0]   core_int,
    input  logic [NUM_IN-1:0]    pad_in,
    input  logic [NUM_BIDIR-1:0] pad_bidir_in,
    output logic [NUM_OUT-1:0]   pad_obuf,
    output logic [NUM_BIDIR-1:0] pad_bidir_out,
    output logic [NUM_BIDIR-1:0] pad_bidir_oe,
    output logic [NUM_IN-1:0]    core_in,
    output logic [NUM_BIDIR-1:0] core_bidir_in
);
    import bscan_pkg::*;

    localparam int CHAIN_LEN = 2 * NUM_BIDIR + NUM_OUT + NUM_IN + NUM_INT;
    localparam int UPD_LEN   = 2 * NUM_BIDIR + NUM_OUT;

    function automatic logic [CHAIN_LEN-1:0] ctrl_mask_f();
        logic [CHAIN_LEN-1:0] m;
        m = '0;
        for (int i = 0; i < CHAIN_LEN; i++)
            if (kind_at(i, NUM_BIDIR, NUM_OUT, NUM_IN) == CELL_BCTRL) m[i] = 1'b1;
        return m;
    endfunction

    // R1: control cells reset to the safe (disabled) value
    localparam logic [CHAIN_LEN-1:0] SHIFT_RST = ctrl_mask_f();
    localparam logic [UPD_LEN-1:0]   UPD_RST   = SHIFT_RST[UPD_LEN-1:0];

    logic [CHAIN_LEN-1:0] cap_vec;
    logic [CHAIN_LEN-1:0] shift_cells;
    logic [UPD_LEN-1:0]   upd_latch;

    bscan_capture_route #(
        .NUM_BIDIR(NUM_BIDIR), .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN), .NUM_INT(NUM_INT)
    ) u_route (
        .core_obuf     (core_obuf),
        .core_bidir_oe (core_bidir_oe),
        .pad_bidir_in  (pad_bidir_in),
        .pad_in        (pad_in),
        .core_int      (core_int),
        .cap_vec       (cap_vec)
    );

    bscan_shift_path #(
        .CHAIN_LEN(CHAIN_LEN), .RST_VEC(SHIFT_RST)
    ) u_shift (
        .tck        (tck),
        .trst_n     (trst_n),
        .tdi        (tdi),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .cap_vec    (cap_vec),
        .cells      (shift_cells),
        .tdo        (tdo)
    );

    bscan_update_bank #(
        .UPD_LEN(UPD_LEN), .RST_VEC(UPD_RST)
    ) u_update (
        .tck         (tck),
        .trst_n      (trst_n),
        .update_en   (update_en),
        .shift_cells (shift_cells[UPD_LEN-1:0]),
        .latch       (upd_latch)
    );

    bscan_pad_mux #(
        .NUM_BIDIR(NUM_BIDIR), .NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)
    ) u_mux (
        .mode            (mode),
        .latch           (upd_latch),
        .core_obuf       (core_obuf),
        .core_bidir_data (core_bidir_data),
        .core_bidir_oe   (core_bidir_oe),
        .pad_bidir_in    (pad_bidir_in),
        .pad_in          (pad_in),
        .pad_obuf        (pad_obuf),
        .pad_bidir_out   (pad_bidir_out),
        .pad_bidir_oe    (pad_bidir_oe),
        .core_in         (core_in),
        .core_bidir_in   (core_bidir_in)
    );

    assert_core_bypass_R2: assert property (@(posedge tck) disable iff (!trst_n)
        !mode |-> (pad_obuf == core_obuf && pad_bidir_oe == core_bidir_oe
                   && pad_bidir_out == core_bidir_data));
    assert_tdo_follows_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (shift_en && !capture_en) |=> tdo == $past(shift_cells[1]));
    assert_pads_hold_R6: assert property (@(posedge tck) disable iff (!trst_n)
        (mode && $stable(mode) && !$past(update_en) && !update_en)
            |-> ($stable(pad_obuf) && $stable(pad_bidir_oe) && $stable(pad_bidir_out)));

endmodule

// File: tb/bscan_pin_chain_test.sv
module bscan_pin_chain_test;
    localparam int NB = 4, NO = 3, NI = 3, NT = 2;
    localparam int L  = 2 * NB + NO + NI + NT;

    logic tck = 1'b0, trst_n = 1'b0, tdi = 1'b0;
    logic capture_en = 1'b0, shift_en = 1'b0, update_en = 1'b0, mode = 1'b0;
    logic tdo;
    logic [NO-1:0] core_obuf = '0;
    logic [NB-1:0] core_bidir_data = '0, core_bidir_oe = '0, pad_bidir_in = '0;
    logic [NT-1:0] core_int = '0;
    logic [NI-1:0] pad_in = '0;
    logic [NO-1:0] pad_obuf;
    logic [NB-1:0] pad_bidir_out, pad_bidir_oe, core_bidir_in;
    logic [NI-1:0] core_in;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 tck = ~tck;

    bscan_pin_chain #(.NUM_BIDIR(NB), .NUM_OUT(NO), .NUM_IN(NI), .NUM_INT(NT)) uut (
        .tck(tck), .trst_n(trst_n), .tdi(tdi), .capture_en(capture_en),
        .shift_en(shift_en), .update_en(update_en), .mode(mode), .tdo(tdo),
        .core_obuf(core_obuf), .core_bidir_data(core_bidir_data),
        .core_bidir_oe(core_bidir_oe), .core_int(core_int), .pad_in(pad_in),
        .pad_bidir_in(pad_bidir_in), .pad_obuf(pad_obuf),
        .pad_bidir_out(pad_bidir_out), .pad_bidir_oe(pad_bidir_oe),
        .core_in(core_in), .core_bidir_in(core_bidir_in)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge tck);
        #1;
    endtask

    task automatic scan(input logic [L-1:0] vin, output logic [L-1:0] vout);
        shift_en = 1'b1;
        for (int i = 0; i < L; i++) begin
            tdi = vin[i];
            vout[i] = tdo;
            step();
        end
        shift_en = 1'b0;
        tdi = 1'b0;
    endtask

    task automatic do_update();
        update_en = 1'b1;
        step();
        update_en = 1'b0;
    endtask

    function automatic logic [L-1:0] ctrl_mask();
        logic [L-1:0] m = '0;
        for (int k = 0; k < NB; k++) m[2*k+1] = 1'b1;
        return m;
    endfunction

    function automatic logic [L-1:0] expect_cap();
        logic [L-1:0] v = '0;
        for (int k = 0; k < NB; k++) begin
            v[2*k]   = pad_bidir_in[k];
            v[2*k+1] = ~core_bidir_oe[k];
        end
        for (int j = 0; j < NO; j++) v[2*NB+j] = core_obuf[j];
        for (int j = 0; j < NI; j++) v[2*NB+NO+j] = pad_in[j];
        for (int j = 0; j < NT; j++) v[2*NB+NO+NI+j] = core_int[j];
        return v;
    endfunction

    task automatic check_pads_from(input string req, input logic [L-1:0] v);
        logic [NB-1:0] ed, eo;
        logic [NO-1:0] eb;
        for (int k = 0; k < NB; k++) begin
            ed[k] = v[2*k];
            eo[k] = ~v[2*k+1];
        end
        for (int j = 0; j < NO; j++) eb[j] = v[2*NB+j];
        check({req, " pad data"},   64'(pad_bidir_out), 64'(ed));
        check({req, " pad enable"}, 64'(pad_bidir_oe),  64'(eo));
        check({req, " pad obuf"},   64'(pad_obuf),      64'(eb));
    endtask

    task automatic load_inputs(input logic [31:0] h);
        core_obuf       = h[2:0];
        core_bidir_data = h[6:3];
        core_bidir_oe   = h[10:7];
        pad_bidir_in    = h[14:11];
        pad_in          = h[17:15];
        core_int        = h[19:18];
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [L-1:0] got, a, b;
        logic [31:0] h;
        repeat (3) step();
        // R1: reset state visible at the pads in mode 1
        mode = 1'b1;
        #1;
        check("R1 reset pad enable", 64'(pad_bidir_oe), 64'(0));
        check("R1 reset pad data",   64'(pad_bidir_out), 64'(0));
        check("R1 reset pad obuf",   64'(pad_obuf), 64'(0));
        trst_n = 1'b1;
        step();
        // R1/R5: reset contents of the shift stage, control cells at 2k+1
        scan('0, got);
        check("R1 R5 reset chain", 64'(got), 64'(ctrl_mask()));

        // R2: bypass sweep with mode low
        mode = 1'b0;
        for (int p = 0; p < 16; p++) begin
            h = 32'(p) * 32'h9E3779B1 + 32'h01234567;
            load_inputs(h);
            #1;
            check("R2 bypass obuf",   64'(pad_obuf), 64'(core_obuf));
            check("R2 bypass data",   64'(pad_bidir_out), 64'(core_bidir_data));
            check("R2 bypass enable", 64'(pad_bidir_oe), 64'(core_bidir_oe));
            check("R2 core_in",       64'(core_in), 64'(pad_in));
            check("R2 core_bidir_in", 64'(core_bidir_in), 64'(pad_bidir_in));
        end

        // R4/R5: capture sweep
        for (int p = 0; p < 32; p++) begin
            h = 32'(p) * 32'h85EBCA6B + 32'h0BADF00D;
            load_inputs(h);
            capture_en = 1'b1;
            step();
            capture_en = 1'b0;
            scan('0, got);
            check("R4 R5 capture", 64'(got), 64'(expect_cap()));
        end

        // R6/R7: shift-only leaves pads; update drives them
        mode = 1'b1;
        a = ctrl_mask();
        for (int p = 0; p < 32; p++) begin
            h = 32'(p) * 32'hC2B2AE35 + 32'h5A5A1234;
            b = h[L-1:0];
            b[3:0] = 4'(p);              // vary bidir pin 0/1 data+control
            b[7:4] = 4'(p >> 1);
            scan(b, got);
            check_pads_from("R6 no update", a);
            do_update();
            check_pads_from("R7 after update", b);
            a = b;
        end

        // R3: serial order through two consecutive scans
        a = 16'hC35A;
        b = 16'h1E97;
        scan(a, got);
        scan(b, got);
        check("R3 serial readback", 64'(got), 64'(a));

        // R8: capture and shift on the same edge
        h = 32'h0007A5C3;
        load_inputs(h);
        tdi = 1'b1;
        capture_en = 1'b1;
        shift_en = 1'b1;
        step();
        capture_en = 1'b0;
        shift_en = 1'b0;
        scan('0, got);
        check("R8 capture priority", 64'(got), 64'(expect_cap()));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule